// File: doc/BRIEF.md
# Self-Routing Omega Switching Network

This block moves fixed-size cells from N input lanes to N output lanes. It uses a multistage network of 2x2 switching elements. There are log2(N) stages, and each stage holds N/2 elements. A perfect-shuffle wiring sits in front of every stage. Each input lane carries a valid flag, a destination port number and a payload. The block turns the destination into a routing tag by reversing its bit order. Each stage then steers a cell using only the tag bit that belongs to that stage, so no central scheduler is needed.

Each stage is registered. A complete new set of cells can be presented on every clock, and every cell reaches its output after exactly log2(N) cycles. The elements hold no buffers. When two cells ask for the same output of an element, the cell on the element's upper input moves on and the lower one is discarded. The stage where that happened raises a drop pulse. The outputs present the delivered payloads with per-lane valid flags.

Top module: `omega_net`

## Requirements
- R1: A cell presented in clock cycle t shows up on the outputs in cycle t+log2(N), which is t+3 for N=8. A new set of cells may be presented on every cycle, with no gaps between sets.
- R2: The routing tag is the destination bits in reversed order. Stage i looks at tag bit i, which is destination bit log2(N)-1-i. A 0 sends the cell to the element's upper output and a 1 sends it to the lower output. As a result, a cell travelling alone from any input arrives at the output lane equal to its destination, with its payload unchanged.
- R3: Stage input position j is fed by previous-stage output position (j>>1) | ((j&1)<<(log2(N)-1)). For N=8 this gives the order 0,4,1,5,2,6,3,7. Element k takes positions 2k (upper) and 2k+1 (lower), and drives its upper output to position 2k and its lower output to position 2k+1. Any set of cells that never meets at an element output is delivered in full.
- R4: When both inputs of an element ask for the same output, the cell on the upper input is forwarded and the cell on the lower input is discarded. A discarded cell never appears on any output.
- R5: Bit s of `drop_pulse` is high for exactly one cycle, s+1 cycles after the set of cells was presented, if at least one element in stage s discarded a cell from that set. Otherwise the bit is low.
- R6: A lane whose `in_valid` bit is 0 is ignored, whatever its destination and payload hold. It produces no output and causes no drop.
- R7: While reset is applied, all `out_valid` and `drop_pulse` bits are 0, and cells presented during reset are not delivered.
- R8: An output lane whose `out_valid` bit is 0 presents an all-zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | N | Per-lane cell present flag |
| in_dest | input | N*log2(N) | Destination port of each lane; lane i uses bits [i*log2(N) +: log2(N)] |
| in_data | input | N*DW | Payload of each lane; lane i uses bits [i*DW +: DW] |
| out_valid | output | N | Per-lane delivered flag |
| out_data | output | N*DW | Delivered payload of each lane; zero when the lane is not valid |
| drop_pulse | output | log2(N) | Per-stage pulse: a cell was discarded in that stage |

## Verification
A wrong element position or a miswired shuffle sends a cell to the wrong lane, or drops it where no conflict exists. The error appears at the outputs exactly three cycles after the offending set was presented. Every cycle is compared against a model of the network built from the rules above. A wrong priority or a mistimed drop flag shows up within one to three cycles on `drop_pulse` or on the payload of the contended output. Contention patterns such as hot spots and random destinations expose these faults.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Setting of a 2x2 element
  typedef enum logic {
    POS_THROUGH = 1'b0,
    POS_CROSSED = 1'b1
  } sw_pos_e;

  // Which previous-stage position feeds stage position j (perfect shuffle)
  function automatic int unsigned shuf_src(input int unsigned j, input int unsigned aw);
    return (j >> 1) | ((j & 1) << (aw - 1));
  endfunction

endpackage

// File: rtl/omega_element.sv
module omega_element
  import omega_pkg::*;
#(
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 16,
  parameter int unsigned STG = 0,
  localparam int unsigned CW = 1 + AW + DW
) (
  input  logic [CW-1:0] up_i,
  input  logic [CW-1:0] lo_i,
  output logic [CW-1:0] up_o,
  output logic [CW-1:0] lo_o,
  output logic          drop_o
);

  localparam int unsigned VB = CW - 1;
  localparam int unsigned TB = DW + STG;

  logic          u_v, l_v, u_b, l_b, clash;
  sw_pos_e       pos;
  logic [CW-1:0] a_cell, b_cell;

  always_comb begin
    u_v   = up_i[VB];
    l_v   = lo_i[VB];
    u_b   = up_i[TB];
    l_b   = lo_i[TB];
    clash = u_v && l_v && (u_b == l_b);

    // upper input decides the setting; otherwise the lower one
    if (u_v)      pos = u_b ? POS_CROSSED : POS_THROUGH;
    else if (l_v) pos = l_b ? POS_THROUGH : POS_CROSSED;
    else          pos = POS_THROUGH;

    a_cell = u_v ? up_i : '0;
    b_cell = (l_v && !clash) ? lo_i : '0;

    if (pos == POS_THROUGH) begin
      up_o = a_cell;
      lo_o = b_cell;
    end else begin
      up_o = b_cell;
      lo_o = a_cell;
    end
    drop_o = clash;
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int unsigned N   = 8,
  parameter int unsigned DW  = 16,
  parameter int unsigned STG = 0,
  localparam int unsigned AW = $clog2(N),
  localparam int unsigned CW = 1 + AW + DW,
  localparam int unsigned NE = N / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*CW-1:0] cells_i,
  output logic [N*CW-1:0] cells_o,
  output logic            drop_o
);

  logic [N*CW-1:0] shf;
  logic [N*CW-1:0] cells_nxt;
  logic [NE-1:0]   el_drop;
  logic            drop_nxt;

  // shuffle wiring in front of the element row
  for (genvar j = 0; j < N; j++) begin : g_shuf
    localparam int unsigned SRC = shuf_src(j, AW);
    assign shf[j*CW +: CW] = cells_i[SRC*CW +: CW];
  end

  for (genvar k = 0; k < NE; k++) begin : g_el
    omega_element #(
      .AW (AW),
      .DW (DW),
      .STG(STG)
    ) i_el (
      .up_i  (shf[(2*k)*CW +: CW]),
      .lo_i  (shf[(2*k+1)*CW +: CW]),
      .up_o  (cells_nxt[(2*k)*CW +: CW]),
      .lo_o  (cells_nxt[(2*k+1)*CW +: CW]),
      .drop_o(el_drop[k])
    );
  end

  always_comb begin
    drop_nxt = |el_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_o <= '0;
      drop_o  <= 1'b0;
    end else begin
      cells_o <= cells_nxt;
      drop_o  <= drop_nxt;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 16,
  localparam int unsigned AW     = $clog2(N),
  localparam int unsigned STAGES = AW,
  localparam int unsigned CW     = 1 + AW + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*AW-1:0]   in_dest,
  input  logic [N*DW-1:0]   in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*DW-1:0]   out_data,
  output logic [STAGES-1:0] drop_pulse
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // cell formation: {valid, reversed-destination tag, payload}
  logic [N*CW-1:0] chain [0:STAGES];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [AW-1:0] tag;
    for (genvar b = 0; b < AW; b++) begin : g_bit
      assign tag[b] = in_dest[i*AW + (AW-1-b)];
    end
    assign chain[0][i*CW +: CW] = {in_valid[i], tag, in_data[i*DW +: DW]};
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(
      .N  (N),
      .DW (DW),
      .STG(s)
    ) i_stage (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cells_i(chain[s]),
      .cells_o(chain[s+1]),
      .drop_o (drop_pulse[s])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign out_valid[i]          = chain[STAGES][i*CW + CW - 1];
    assign out_data[i*DW +: DW]  = chain[STAGES][i*CW +: DW];
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned DW     = 16,
  parameter int unsigned STAGES = 3
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [N-1:0]      in_valid,
  input logic [N-1:0]      out_valid,
  input logic [N*DW-1:0]   out_data,
  input logic [STAGES-1:0] drop_pulse
);

  int unsigned cyc;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)            cyc <= 0;
    else if (cyc <= STAGES)  cyc <= cyc + 1;
  end

  AST_NO_GHOST_OUT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc >= STAGES && $past(in_valid, STAGES) == '0) |-> out_valid == '0); // R6

  AST_OUT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_q_n)
    cyc >= STAGES |-> $countones(out_valid) <= $countones($past(in_valid, STAGES))); // R2

  AST_DROP_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc >= 1 && drop_pulse[0]) |-> $countones($past(in_valid)) >= 2); // R4

  AST_QUIET_NO_DROP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc >= 1 && $past(in_valid) == '0) |-> !drop_pulse[0]); // R5

  for (genvar i = 0; i < N; i++) begin : g_lane_chk
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
      !out_valid[i] |-> out_data[i*DW +: DW] == '0); // R8
  end

endmodule

bind omega_net omega_net_chk #(
  .N     (N),
  .DW    (DW),
  .STAGES(STAGES)
) i_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .drop_pulse(drop_pulse)
);

// File: tb/test_omega_net.sv
module test_omega_net;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int S  = 3;

  typedef struct packed {
    logic [N-1:0]    v;
    logic [N*DW-1:0] d;
    logic [S-1:0]    drop;
    logic [3:0]      req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      in_valid;
  logic [N*AW-1:0]   in_dest;
  logic [N*DW-1:0]   in_data;
  logic [N-1:0]      out_valid;
  logic [N*DW-1:0]   out_data;
  logic [S-1:0]      drop_pulse;

  int tests = 0;
  int fails = 0;
  int unsigned seed = 32'h1234_5678;
  item_t q[$];
  item_t pipe [S];
  bit    done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  omega_net #(.N(N), .DW(DW)) i_omega_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .drop_pulse(drop_pulse)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      6: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // reference network built from R2, R3, R4, R5, R6, R8
  function automatic item_t model(input logic [N-1:0] v, input logic [N*AW-1:0] dst,
                                  input logic [N*DW-1:0] dat, input logic [3:0] req);
    item_t r;
    logic          cv [N];
    logic [AW-1:0] cd [N];
    logic [DW-1:0] cp [N];
    logic          nv [N];
    logic [AW-1:0] nd [N];
    logic [DW-1:0] np [N];
    r = '0;
    r.req = req;
    for (int i = 0; i < N; i++) begin
      cv[i] = v[i]; cd[i] = dst[i*AW +: AW]; cp[i] = dat[i*DW +: DW];
    end
    for (int s = 0; s < S; s++) begin
      for (int j = 0; j < N; j++) begin
        int src;
        src = (j >> 1) | ((j & 1) << (AW-1));
        nv[j] = cv[src]; nd[j] = cd[src]; np[j] = cp[src];
      end
      for (int k = 0; k < N/2; k++) begin
        logic ub, lb, uv, lv;
        uv = nv[2*k]; lv = nv[2*k+1];
        ub = nd[2*k][AW-1-s]; lb = nd[2*k+1][AW-1-s];
        for (int t = 0; t < 2; t++) begin
          cv[2*k+t] = 1'b0; cd[2*k+t] = '0; cp[2*k+t] = '0;
        end
        if (uv) begin
          cv[2*k+ub] = 1'b1; cd[2*k+ub] = nd[2*k]; cp[2*k+ub] = np[2*k];
        end
        if (lv) begin
          if (uv && ub == lb) r.drop[s] = 1'b1;
          else begin
            cv[2*k+lb] = 1'b1; cd[2*k+lb] = nd[2*k+1]; cp[2*k+lb] = np[2*k+1];
          end
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      r.v[i] = cv[i];
      r.d[i*DW +: DW] = cv[i] ? cp[i] : '0;
    end
    return r;
  endfunction

  // driver: one call per cycle
  task automatic send(input logic [N-1:0] v, input logic [N*AW-1:0] dst,
                      input logic [N*DW-1:0] dat, input logic [3:0] req);
    @(negedge clk);
    in_valid = v; in_dest = dst; in_data = dat;
    q.push_back(model(v, dst, dat, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('0, '0, '0, 4'd6);
  endtask

  // monitor: pipe[s] mirrors what stage s holds after the edge
  initial begin
    for (int s = 0; s < S; s++) pipe[s] = '0;
    forever begin
      @(posedge clk);
      if (rst_n && !done) begin
        for (int s = S-1; s > 0; s--) pipe[s] = pipe[s-1];
        pipe[0] = (q.size() > 0) ? q.pop_front() : '0;
        #1;
        tests++;
        if (out_valid !== pipe[S-1].v) begin
          fails++;
          $display("FAIL %s valid: got %b exp %b", rname(pipe[S-1].req), out_valid, pipe[S-1].v);
        end
        tests++;
        for (int i = 0; i < N; i++) begin
          if (pipe[S-1].v[i] && out_data[i*DW +: DW] !== pipe[S-1].d[i*DW +: DW]) begin
            fails++;
            $display("FAIL %s lane %0d data: got %h exp %h", rname(pipe[S-1].req), i,
                     out_data[i*DW +: DW], pipe[S-1].d[i*DW +: DW]);
          end
          if (!out_valid[i] && out_data[i*DW +: DW] !== '0) begin
            fails++;
            $display("FAIL R8 lane %0d idle data: got %h exp 0", i, out_data[i*DW +: DW]);
          end
        end
        tests++;
        for (int s = 0; s < S; s++) begin
          if (drop_pulse[s] !== pipe[s].drop[s]) begin
            fails++;
            $display("FAIL R5 stage %0d drop: got %b exp %b", s, drop_pulse[s], pipe[s].drop[s]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] dv;
    logic [N*DW-1:0] pv;
    rst_n = 1'b0;
    in_valid = '1; in_dest = '1; in_data = '1;
    repeat (4) @(negedge clk);
    // R7: reset state with busy inputs
    tests++;
    if (out_valid !== '0 || drop_pulse !== '0) begin
      fails++;
      $display("FAIL R7 reset: got %b/%b exp 0/0", out_valid, drop_pulse);
    end
    in_valid = '0; in_dest = '0; in_data = '0;
    @(negedge clk);
    rst_n = 1'b1;
    // R7: nothing presented during reset leaks out
    repeat (5) @(negedge clk);
    tests++;
    if (out_valid !== '0 || drop_pulse !== '0) begin
      fails++;
      $display("FAIL R7 after reset: got %b/%b exp 0/0", out_valid, drop_pulse);
    end
    idle(2);

    // R1/R2: single cells from every input to every output, back to back
    for (int src = 0; src < N; src++)
      for (int d = 0; d < N; d++) begin
        dv = '0; pv = '0;
        dv[src*AW +: AW] = AW'(d);
        pv[src*DW +: DW] = DW'(16'hA000 | (src << 4) | d);
        send(N'(1) << src, dv, pv, (d == 0) ? 4'd1 : 4'd2);
      end
    idle(3);

    // R3: cyclic shift permutations, full load
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++) begin
        dv[i*AW +: AW] = AW'((i + k) % N);
        pv[i*DW +: DW] = DW'(16'h3000 | (k << 4) | i);
      end
      send('1, dv, pv, 4'd3);
    end
    // R3: identity and bit reversal
    for (int i = 0; i < N; i++) begin
      dv[i*AW +: AW] = AW'(i);
      pv[i*DW +: DW] = DW'(16'h3100 | i);
    end
    send('1, dv, pv, 4'd3);
    for (int i = 0; i < N; i++) begin
      dv[i*AW +: AW] = {AW'(i)}[0] ? AW'({i[0], i[1], i[2]}) : AW'({i[0], i[1], i[2]});
      pv[i*DW +: DW] = DW'(16'h3200 | i);
    end
    send('1, dv, pv, 4'd3);
    idle(3);

    // R4: inputs 0 and 4 share element 0 of stage 0 and both head for port 0
    dv = '0; pv = '0;
    pv[0*DW +: DW] = 16'h4444; pv[4*DW +: DW] = 16'h5555;
    send(8'b0001_0001, dv, pv, 4'd4);
    idle(3);
    // R4: hot spot, all lanes to port 5
    for (int i = 0; i < N; i++) begin
      dv[i*AW +: AW] = AW'(5);
      pv[i*DW +: DW] = DW'(16'h4500 | i);
    end
    send('1, dv, pv, 4'd4);
    idle(3);

    // R6: junk on invalid lanes
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < N; i++) begin
        dv[i*AW +: AW] = AW'(rnd());
        pv[i*DW +: DW] = DW'(rnd());
      end
      send(N'(n == 0 ? 0 : (8'h01 << n)), dv, pv, 4'd6);
    end
    idle(3);

    // R4/R5: random load with contention
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < N; i++) begin
        dv[i*AW +: AW] = AW'(rnd());
        pv[i*DW +: DW] = DW'(rnd());
      end
      send(N'(rnd()), dv, pv, 4'd4);
    end
    idle(S + 2);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule